// File: doc/BRIEF.md
# Half-Bridge Gate Command Controller

This block sits between a modulator and the two gate drive stages of a half bridge. It takes a high-side command and a low-side command, both active high. It produces two gate-enable outputs that follow the commands in phase. Each command passes through a two-flop synchronizer and then a pulse-width filter. The filter ignores a level change of either polarity unless the change holds for a set number of clocks.

The filtered commands go to an interlock core. The core turns both outputs off whenever both commands are asserted. It holds off a turn-on until the opposite output has been off for a deadtime, and each side has its own deadtime. Each channel has a supply-good flag, filtered with separate loss and recovery delays. A low-side supply loss blanks both outputs. A high-side supply loss blanks only the high-side output.

The high-side output then crosses a short transfer pipeline. The low-side output passes an equal matching pipeline, so both channels see the same latency. Every delay is given in nanoseconds and turned into clock cycles by rounding up against the clock period parameter.

Top module: `hb_gate_ctrl`

## Requirements
- R1: Outputs are non-inverting. A command held high gives a high output on that channel, and a command held low gives a low output.
- R2: A command level change lasting fewer than MPW clock cycles has no effect on the output, for both positive and negative pulses. A change lasting MPW cycles or more reaches the output. MPW is FILTER_NS divided by CLK_NS, rounded up.
- R3: While both commands are high, both outputs are low.
- R4: The two outputs are never high in the same cycle.
- R5: The high-side output rises no sooner than DT_HS cycles after the low-side output falls. On a direct handoff the gap is exactly DT_HS cycles, with DT_HS = ceil(DT_HS_NS/CLK_NS).
- R6: The low-side output rises no sooner than DT_LS cycles after the high-side output falls. On a direct handoff the gap is exactly DT_LS cycles, with DT_LS = ceil(DT_LS_NS/CLK_NS).
- R7: The latency from a command edge to the output edge is 3 + MPW + XFER_CYC cycles on both channels, for both rising and falling edges.
- R8: A supply-good loss shorter than FALL cycles is ignored. A loss that persists forces the affected output low exactly 3 + FALL + XFER_CYC cycles after it starts, with FALL = ceil(UV_FALL_NS/CLK_NS).
- R9: After supply-good returns, the output follows its command again exactly 3 + RISE + XFER_CYC cycles later, with RISE = ceil(UV_RISE_NS/CLK_NS).
- R10: A low-side supply loss forces both outputs low. A high-side supply loss forces only the high-side output low.
- R11: During reset both outputs are low. After reset, both supplies count as bad until their recovery delay has elapsed.
- R12: If a command is withdrawn while its deadtime is still running, the pending turn-on is dropped and that output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_cmd_i | input | 1 | High-side command, active high, asynchronous |
| ls_cmd_i | input | 1 | Low-side command, active high, asynchronous |
| hs_supply_ok_i | input | 1 | High-side supply-good flag, asynchronous |
| ls_supply_ok_i | input | 1 | Low-side supply-good flag, asynchronous |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
Suppose a filter or supply counter lands in the wrong state. An output edge then appears one or more cycles away from its computed slot, or a sub-threshold pulse leaks through within about MPW + XFER_CYC cycles of the stimulus. A fault in a deadtime counter shows up as a handoff gap that differs from DT_HS or DT_LS. Depending on the fault, the gap may also shrink to zero, with both outputs high at once, and that is visible on the first handoff. A wrong channel mask for the supply shows within FALL + XFER_CYC cycles as an output that stays high when it should be forced low, or one that drops on the other supply's loss.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Channel index used for vectors carrying one bit per side.
  localparam int CH_HS = 0;
  localparam int CH_LS = 1;
  localparam int N_CH  = 2;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/hb_debounce.sv
// Level qualifier: the output takes a new level only after the input has
// disagreed with it for RISE_CYC (towards 1) or FALL_CYC (towards 0)
// consecutive cycles. Any agreeing cycle restarts the count.
module hb_debounce #(
  parameter int RISE_CYC = 2,
  parameter int FALL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int MAXC = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] FALL_LIM = CW'(FALL_CYC - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  always_comb begin
    lim    = lvl_q ? FALL_LIM : RISE_LIM;
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    if (din == lvl_q) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q == lim) begin
      lvl_d  = din;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign dout = lvl_q;

endmodule

// File: rtl/hb_gap_timer.sv
// Counts cycles during which the opposite output has been off, saturating
// at GAP-1; ready means this side may turn on in the next cycle.
module hb_gap_timer #(
  parameter int GAP = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic other_on,
  output logic ready
);

  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] LIM = CW'(GAP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (other_on) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = !other_on && (cnt_q == LIM);

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
  parameter int DT_HS_CYC = 34,
  parameter int DT_LS_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd,
  input  logic ls_cmd,
  input  logic hs_ok,
  input  logic ls_ok,
  output logic hs_on,
  output logic ls_on
);

  logic hs_req, ls_req;
  logic hs_ready, ls_ready;
  logic hs_on_d, ls_on_d;

  // Contradictory commands blank both sides; the low-side supply also
  // powers the high-side path, so its loss masks both requests.
  assign hs_req = hs_cmd && !ls_cmd && hs_ok && ls_ok;
  assign ls_req = ls_cmd && !hs_cmd && ls_ok;

  hb_gap_timer #(.GAP(DT_HS_CYC)) u_hs_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .other_on (ls_on),
    .ready    (hs_ready)
  );

  hb_gap_timer #(.GAP(DT_LS_CYC)) u_ls_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .other_on (hs_on),
    .ready    (ls_ready)
  );

  always_comb begin
    hs_on_d = hs_req && hs_ready;
    ls_on_d = ls_req && ls_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on <= 1'b0;
      ls_on <= 1'b0;
    end else begin
      hs_on <= hs_on_d;
      ls_on <= ls_on_d;
    end
  end

endmodule

// File: rtl/hb_delay_line.sv
module hb_delay_line #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else if (DEPTH == 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= 1'b0;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_shift
      logic [DEPTH-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DEPTH-2:0], d};
      end
      assign q = sr_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int FILTER_NS  = 20,
  parameter int DT_HS_NS   = 340,
  parameter int DT_LS_NS   = 350,
  parameter int UV_FALL_NS = 1300,
  parameter int UV_RISE_NS = 1100,
  parameter int XFER_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd_i,
  input  logic ls_cmd_i,
  input  logic hs_supply_ok_i,
  input  logic ls_supply_ok_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);

  localparam int MPW_CYC   = ns_to_cyc(FILTER_NS, CLK_NS);
  localparam int DT_HS_CYC = ns_to_cyc(DT_HS_NS, CLK_NS);
  localparam int DT_LS_CYC = ns_to_cyc(DT_LS_NS, CLK_NS);
  localparam int FALL_CYC  = ns_to_cyc(UV_FALL_NS, CLK_NS);
  localparam int RISE_CYC  = ns_to_cyc(UV_RISE_NS, CLK_NS);

  // Reset: asserted at once, released after two clean edges.
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // Synchronized inputs: [1:0] commands, [3:2] supply flags.
  logic [2*N_CH-1:0] raw_in, sync_in;
  logic [N_CH-1:0]   cmd_f, sup_f, on_core, gate;

  assign raw_in = {ls_supply_ok_i, hs_supply_ok_i, ls_cmd_i, hs_cmd_i};

  hb_sync #(.W(2*N_CH)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      hb_debounce #(.RISE_CYC(MPW_CYC), .FALL_CYC(MPW_CYC)) u_cmd_filt (
        .clk   (clk),
        .rst_n (core_rst_n),
        .din   (sync_in[c]),
        .dout  (cmd_f[c])
      );

      hb_debounce #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_sup_filt (
        .clk   (clk),
        .rst_n (core_rst_n),
        .din   (sync_in[N_CH + c]),
        .dout  (sup_f[c])
      );

      // High side: transfer pipeline; low side: equal matching pipeline.
      hb_delay_line #(.DEPTH(XFER_CYC)) u_out_dly (
        .clk   (clk),
        .rst_n (core_rst_n),
        .d     (on_core[c]),
        .q     (gate[c])
      );
    end
  endgenerate

  hb_interlock #(.DT_HS_CYC(DT_HS_CYC), .DT_LS_CYC(DT_LS_CYC)) u_core (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .hs_cmd (cmd_f[CH_HS]),
    .ls_cmd (cmd_f[CH_LS]),
    .hs_ok  (sup_f[CH_HS]),
    .ls_ok  (sup_f[CH_LS]),
    .hs_on  (on_core[CH_HS]),
    .ls_on  (on_core[CH_LS])
  );

  assign hs_gate_o = gate[CH_HS];
  assign ls_gate_o = gate[CH_LS];

endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk
  import hb_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int DT_HS_NS   = 340,
  parameter int DT_LS_NS   = 350,
  parameter int UV_FALL_NS = 1300,
  parameter int XFER_CYC   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hs_sup,
  input logic ls_sup,
  input logic hs_gate,
  input logic ls_gate
);

  localparam int DT_HS   = ns_to_cyc(DT_HS_NS, CLK_NS);
  localparam int DT_LS   = ns_to_cyc(DT_LS_NS, CLK_NS);
  localparam int FORCE_N = 3 + ns_to_cyc(UV_FALL_NS, CLK_NS) + XFER_CYC;
  localparam int DHW = $clog2(DT_HS + 1);
  localparam int DLW = $clog2(DT_LS + 1);
  localparam int FW  = $clog2(FORCE_N + 1);
  localparam logic [DHW-1:0] DH_MAX = DHW'(DT_HS);
  localparam logic [DLW-1:0] DL_MAX = DLW'(DT_LS);
  localparam logic [FW-1:0]  F_MAX  = FW'(FORCE_N);

  logic [DHW-1:0] ls_off_cnt;
  logic [DLW-1:0] hs_off_cnt;
  logic [FW-1:0]  hs_bad_cnt, ls_bad_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_off_cnt <= '0;
      hs_off_cnt <= '0;
      hs_bad_cnt <= '0;
      ls_bad_cnt <= '0;
    end else begin
      if (ls_gate)                   ls_off_cnt <= '0;
      else if (ls_off_cnt != DH_MAX) ls_off_cnt <= ls_off_cnt + DHW'(1);
      if (hs_gate)                   hs_off_cnt <= '0;
      else if (hs_off_cnt != DL_MAX) hs_off_cnt <= hs_off_cnt + DLW'(1);
      if (hs_sup)                    hs_bad_cnt <= '0;
      else if (hs_bad_cnt != F_MAX)  hs_bad_cnt <= hs_bad_cnt + FW'(1);
      if (ls_sup)                    ls_bad_cnt <= '0;
      else if (ls_bad_cnt != F_MAX)  ls_bad_cnt <= ls_bad_cnt + FW'(1);
    end
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_hs_deadtime_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (ls_off_cnt >= DH_MAX));

  assert_ls_deadtime_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (hs_off_cnt >= DL_MAX));

  assert_hs_supply_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_bad_cnt == F_MAX) |-> !hs_gate);

  assert_ls_supply_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_bad_cnt == F_MAX) |-> (!hs_gate && !ls_gate));

endmodule

bind hb_gate_ctrl hb_gate_chk #(
  .CLK_NS     (CLK_NS),
  .DT_HS_NS   (DT_HS_NS),
  .DT_LS_NS   (DT_LS_NS),
  .UV_FALL_NS (UV_FALL_NS),
  .XFER_CYC   (XFER_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hs_sup  (hs_supply_ok_i),
  .ls_sup  (ls_supply_ok_i),
  .hs_gate (hs_gate_o),
  .ls_gate (ls_gate_o)
);

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int FILTER_NS  = 20;
  localparam int DT_HS_NS   = 340;
  localparam int DT_LS_NS   = 350;
  localparam int FALL_NS    = 1300;
  localparam int RISE_NS    = 1100;
  localparam int XFER       = 2;

  localparam int MPW   = (FILTER_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int DT_HS = (DT_HS_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int DT_LS = (DT_LS_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int FALL  = (FALL_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RISE  = (RISE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int LAT   = 3 + MPW + XFER;

  logic clk = 1'b0;
  logic rst_n, hs_cmd, ls_cmd, hs_sup, ls_sup;
  logic hs_gate, ls_gate;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_gate_ctrl #(
    .CLK_NS     (CLK_PERIOD),
    .FILTER_NS  (FILTER_NS),
    .DT_HS_NS   (DT_HS_NS),
    .DT_LS_NS   (DT_LS_NS),
    .UV_FALL_NS (FALL_NS),
    .UV_RISE_NS (RISE_NS),
    .XFER_CYC   (XFER)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .hs_cmd_i       (hs_cmd),
    .ls_cmd_i       (ls_cmd),
    .hs_supply_ok_i (hs_sup),
    .ls_supply_ok_i (ls_sup),
    .hs_gate_o      (hs_gate),
    .ls_gate_o      (ls_gate)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  function automatic logic out_of(input int ch);
    return (ch == 0) ? hs_gate : ls_gate;
  endfunction

  task automatic set_cmd(input int ch, input logic v);
    if (ch == 0) hs_cmd = v;
    else         ls_cmd = v;
  endtask

  // Pulse of k cycles of polarity pol from the opposite steady level.
  task automatic pulse_test(input int ch, input logic pol, input int k);
    logic seen;
    seen = 1'b0;
    if (!pol) begin
      set_cmd(ch, 1'b1);
      wait_n(60);
    end
    set_cmd(ch, pol);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (out_of(ch) == pol) seen = 1'b1;
    end
    set_cmd(ch, ~pol);
    for (int i = 0; i < LAT + k + 5; i++) begin
      @(negedge clk);
      if (out_of(ch) == pol) seen = 1'b1;
    end
    check($sformatf("R2 ch%0d pol%0b width%0d", ch, pol, k), seen, logic'(k >= MPW));
    set_cmd(ch, 1'b0);
    wait_n(60);
  endtask

  initial begin
    logic ok;
    rst_n = 1'b0; hs_cmd = 1'b0; ls_cmd = 1'b0; hs_sup = 1'b1; ls_sup = 1'b1;
    wait_n(5);
    check("R11 reset hs", hs_gate, 1'b0);
    check("R11 reset ls", ls_gate, 1'b0);
    rst_n = 1'b1;
    hs_cmd = 1'b1;
    wait_n(60);
    check("R11 supply not yet good", hs_gate, 1'b0);
    wait_n(200);
    check("R1 hs follows high", hs_gate, 1'b1);

    // R7 matched latency, both edges, both channels
    hs_cmd = 1'b0;
    wait_n(LAT - 1); check("R7 hs fall early", hs_gate, 1'b1);
    wait_n(1);       check("R7 hs fall", hs_gate, 1'b0);
    wait_n(60);
    ls_cmd = 1'b1;
    wait_n(LAT - 1); check("R7 ls rise early", ls_gate, 1'b0);
    wait_n(1);       check("R7 ls rise", ls_gate, 1'b1);
    ls_cmd = 1'b0;
    wait_n(LAT - 1); check("R7 ls fall early", ls_gate, 1'b1);
    wait_n(1);       check("R1 ls follows low", ls_gate, 1'b0);
    wait_n(60);

    // R2 pulse width sweep
    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 2; p++)
        for (int k = 1; k <= MPW + 2; k++)
          pulse_test(ch, logic'(p), k);

    // R3 / R1 command combinations
    for (int c = 0; c < 4; c++) begin
      hs_cmd = c[1]; ls_cmd = c[0];
      wait_n(100);
      check($sformatf("R3 combo %0d hs", c), hs_gate, logic'(c == 2));
      check($sformatf("R3 combo %0d ls", c), ls_gate, logic'(c == 1));
      hs_cmd = 1'b0; ls_cmd = 1'b0;
      wait_n(60);
    end

    // R5 handoff low to high
    ls_cmd = 1'b1; wait_n(60);
    ls_cmd = 1'b0; hs_cmd = 1'b1;
    wait_n(LAT);           check("R5 ls off", ls_gate, 1'b0);
    wait_n(DT_HS - 1);     check("R5 hs held in deadtime", hs_gate, 1'b0);
    wait_n(1);             check("R5 hs on after deadtime", hs_gate, 1'b1);
    // R6 handoff high to low
    hs_cmd = 1'b0; ls_cmd = 1'b1;
    wait_n(LAT);           check("R6 hs off", hs_gate, 1'b0);
    wait_n(DT_LS - 1);     check("R6 ls held in deadtime", ls_gate, 1'b0);
    wait_n(1);             check("R6 ls on after deadtime", ls_gate, 1'b1);
    wait_n(20);

    // R12 cancel during deadtime
    ls_cmd = 1'b0; hs_cmd = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hs_gate) ok = 1'b0;
    end
    hs_cmd = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hs_gate) ok = 1'b0;
    end
    check("R12 cancelled turn-on stays low", ok, 1'b1);

    // R8 supply loss filter on high side
    hs_cmd = 1'b1; wait_n(60);
    hs_sup = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < FALL - 1; i++) begin
      @(negedge clk);
      if (!hs_gate) ok = 1'b0;
    end
    hs_sup = 1'b1;
    for (int i = 0; i < FALL + 20; i++) begin
      @(negedge clk);
      if (!hs_gate) ok = 1'b0;
    end
    check("R8 short supply dip ignored", ok, 1'b1);
    hs_sup = 1'b0;
    wait_n(2 + FALL + XFER); check("R8 hs before force", hs_gate, 1'b1);
    wait_n(1);               check("R8 hs forced low", hs_gate, 1'b0);
    hs_sup = 1'b1;
    wait_n(2 + RISE + XFER); check("R9 hs before recovery", hs_gate, 1'b0);
    wait_n(1);               check("R9 hs recovered", hs_gate, 1'b1);

    // R10 low-side loss blanks high side
    ls_sup = 1'b0;
    wait_n(2 + FALL + XFER); check("R10 hs before ls-loss force", hs_gate, 1'b1);
    wait_n(1);               check("R10 ls loss forces hs", hs_gate, 1'b0);
    ls_sup = 1'b1;
    wait_n(2 + RISE + XFER); check("R9 hs before ls recovery", hs_gate, 1'b0);
    wait_n(1);               check("R9 hs after ls recovery", hs_gate, 1'b1);
    hs_cmd = 1'b0; wait_n(60);

    // R10 high-side loss leaves low side alone
    ls_cmd = 1'b1; wait_n(60);
    hs_sup = 1'b0;
    wait_n(FALL + 20);
    check("R10 hs loss keeps ls on", ls_gate, 1'b1);
    check("R10 hs stays low", hs_gate, 1'b0);
    hs_sup = 1'b1;
    wait_n(RISE + 20);
    ls_cmd = 1'b0;
    wait_n(LAT + 1);
    check("R1 ls low at end", ls_gate, 1'b0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

endmodule